// File: doc/BRIEF.md
# Handshake-Terminated Bus Write Sequencer

This block is the master-side sequencer for the write half of an asynchronous bus cycle. A cycle is divided into fixed half-clock phases. The block runs from `clk`, which must be twice the bus clock. Each `clk` period is one half-phase, and phases alternate between the rising-edge half and the falling-edge half of the bus clock. The write half starts when `start` is sampled high while the block is idle. The block captures the address, function code, byte enables and write data. Over eight half-phases it then does the following, in order:

- drives the address and the address strobe;
- lowers the read/write line;
- turns on the data drivers;
- asserts the byte strobes that the byte enables select;
- waits for a transfer acknowledge or a bus error;
- releases everything.

If no termination is seen at the end of the strobe phase, the block stretches the cycle by whole bus clocks. Each whole bus clock is two half-phases. It samples again at the end of each such pair. A bus error ends the cycle through the same release sequence and raises `err` in place of `done`.

All bus strobes and terminations are active low. `rd_wr_n` is high for read and low for write.

Top module: `bus_wr_seq`

## Requirements
- R1: After reset and whenever no cycle is active, `addr_strb_n`, `hi_strb_n`, `lo_strb_n` and `rd_wr_n` are 1, and `addr_oe`, `data_oe`, `done` and `err` are 0.
- R2: A `start` sampled high while idle begins a cycle at half-phase 12 on the next `clk` period. `addr_oe` is 1 and `addr_strb_n` is 0 from half-phase 12 through half-phase 18. `addr_out` and `fc_out` carry the values captured at start.
- R3: `rd_wr_n` is 0 from half-phase 14, the third of the cycle, through half-phase 19, and returns to 1 when the cycle ends.
- R4: `data_oe` is 1 from half-phase 15 through half-phase 19. While it is 1, `wdata_out` carries the write data captured at start.
- R5: From half-phase 16 through half-phase 18, including any wait half-phases, `hi_strb_n` is 0 only if captured enable bit 1 is set, and `lo_strb_n` is 0 only if captured enable bit 0 is set.
- R6: Terminations are sampled at the end of half-phase 16 and at the end of each second wait half-phase. With no termination, two wait half-phases are inserted. A cycle that sees its termination at the k-th sample after the first lasts 8+2k half-phases.
- R7: A bus error (`buserr_n` low) ends the cycle through half-phases 17, 18 and 19, like an acknowledge. It raises `err` and not `done`. When both terminations are sampled together, the bus error wins.
- R8: `done` or `err` is 1 for exactly the one half-phase 19. In half-phase 19 `addr_strb_n` and both byte strobes are already 1 and `addr_oe` is still 1. In the next period `addr_oe` and `data_oe` are 0.
- R9: `start` during an active cycle is ignored, so no second cycle follows. Changes on `addr_in`, `fc_in`, `be_in` and `wdata_in` after start do not change the bus outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-phase clock, twice the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the write half |
| addr_in | input | ADDR_W | Address to drive |
| fc_in | input | FC_W | Function code to drive |
| be_in | input | 2 | Byte enables: bit 1 upper, bit 0 lower |
| wdata_in | input | DATA_W | Write data |
| ack_n | input | 1 | Transfer acknowledge, active low |
| buserr_n | input | 1 | Bus error, active low |
| addr_out | output | ADDR_W | Driven address |
| fc_out | output | FC_W | Driven function code |
| addr_oe | output | 1 | Address and function-code drive enable |
| addr_strb_n | output | 1 | Address strobe, active low |
| hi_strb_n | output | 1 | Upper byte strobe, active low |
| lo_strb_n | output | 1 | Lower byte strobe, active low |
| rd_wr_n | output | 1 | High read, low write |
| wdata_out | output | DATA_W | Driven write data |
| data_oe | output | 1 | Data-bus drive enable |
| done | output | 1 | Cycle ended by acknowledge |
| err | output | 1 | Cycle ended by bus error |

## Verification
Cycles are run with 0 to 6 wait clocks before the termination. This shows whether the block samples only at the strobe phase and at the end of each wait pair, and whether it stretches in whole clocks. Upper-only, lower-only, word and no-enable writes show that each strobe follows its own enable. Acknowledge, bus error and both together distinguish `done` from `err` and show that the bus error has priority. Two more stimuli show that captured values are held: a termination held low from the start of the cycle, and `start` or data changes in the middle of a cycle.

// File: rtl/bus_wr_seq_pkg.sv
package bus_wr_seq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE = 4'd0,
    PH_12   = 4'd1,
    PH_13   = 4'd2,
    PH_14   = 4'd3,
    PH_15   = 4'd4,
    PH_16   = 4'd5,
    PH_WA   = 4'd6,
    PH_WB   = 4'd7,
    PH_17   = 4'd8,
    PH_18   = 4'd9,
    PH_19   = 4'd10
  } wph_t;
endpackage

// File: rtl/bus_wr_seq_fsm.sv
module bus_wr_seq_fsm
  import bus_wr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_n,
  input  logic buserr_n,
  output wph_t phase,
  output logic term_err
);
  wph_t phase_nxt;
  logic term_seen;
  logic sample_pt;

  assign sample_pt = (phase == PH_16) || (phase == PH_WB);
  assign term_seen = sample_pt && (!ack_n || !buserr_n);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE: if (start) phase_nxt = PH_12;
      PH_12:   phase_nxt = PH_13;
      PH_13:   phase_nxt = PH_14;
      PH_14:   phase_nxt = PH_15;
      PH_15:   phase_nxt = PH_16;
      PH_16:   phase_nxt = term_seen ? PH_17 : PH_WA;
      PH_WA:   phase_nxt = PH_WB;
      PH_WB:   phase_nxt = term_seen ? PH_17 : PH_WA;
      PH_17:   phase_nxt = PH_18;
      PH_18:   phase_nxt = PH_19;
      PH_19:   phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phase_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_err <= 1'b0;
    end else if (term_seen) begin
      term_err <= !buserr_n;
    end
  end
endmodule

// File: rtl/bus_wr_seq_drive.sv
module bus_wr_seq_drive
  import bus_wr_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  wph_t              phase,
  input  logic              term_err,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [FC_W-1:0]   fc_in,
  input  logic [1:0]        be_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [FC_W-1:0]   fc_out,
  output logic              addr_oe,
  output logic              addr_strb_n,
  output logic              hi_strb_n,
  output logic              lo_strb_n,
  output logic              rd_wr_n,
  output logic [DATA_W-1:0] wdata_out,
  output logic              data_oe,
  output logic              done,
  output logic              err
);
  localparam int LANES = 2;

  logic              cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic [FC_W-1:0]   fc_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] data_q;
  logic              in_cycle, in_write, in_data, in_strobe;
  logic [LANES-1:0]  strb_n;

  assign cap_en = (phase == PH_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      fc_q   <= '0;
      be_q   <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_in;
      fc_q   <= fc_in;
      be_q   <= be_in;
      data_q <= wdata_in;
    end
  end

  always_comb begin
    in_cycle  = (phase != PH_IDLE);
    in_write  = 1'b0;
    in_data   = 1'b0;
    in_strobe = 1'b0;
    unique case (phase)
      PH_14:               in_write = 1'b1;
      PH_15:        begin in_write = 1'b1; in_data = 1'b1; end
      PH_16, PH_WA, PH_WB,
      PH_17, PH_18: begin in_write = 1'b1; in_data = 1'b1; in_strobe = 1'b1; end
      PH_19:        begin in_write = 1'b1; in_data = 1'b1; end
      default: ;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb_n[g] = !(in_strobe && be_q[g]);
  end

  assign addr_out    = addr_q;
  assign fc_out      = fc_q;
  assign wdata_out   = data_q;
  assign addr_oe     = in_cycle;
  assign addr_strb_n = !(in_cycle && (phase != PH_19));
  assign hi_strb_n   = strb_n[1];
  assign lo_strb_n   = strb_n[0];
  assign rd_wr_n     = !in_write;
  assign data_oe     = in_data;
  assign done        = (phase == PH_19) && !term_err;
  assign err         = (phase == PH_19) && term_err;
endmodule

// File: rtl/bus_wr_seq.sv
module bus_wr_seq
  import bus_wr_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [FC_W-1:0]   fc_in,
  input  logic [1:0]        be_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              ack_n,
  input  logic              buserr_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic [FC_W-1:0]   fc_out,
  output logic              addr_oe,
  output logic              addr_strb_n,
  output logic              hi_strb_n,
  output logic              lo_strb_n,
  output logic              rd_wr_n,
  output logic [DATA_W-1:0] wdata_out,
  output logic              data_oe,
  output logic              done,
  output logic              err
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  wph_t       phase;
  logic       term_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  bus_wr_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .ack_n    (ack_n),
    .buserr_n (buserr_n),
    .phase    (phase),
    .term_err (term_err)
  );

  bus_wr_seq_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FC_W   (FC_W)
  ) u_drive (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .phase       (phase),
    .term_err    (term_err),
    .addr_in     (addr_in),
    .fc_in       (fc_in),
    .be_in       (be_in),
    .wdata_in    (wdata_in),
    .addr_out    (addr_out),
    .fc_out      (fc_out),
    .addr_oe     (addr_oe),
    .addr_strb_n (addr_strb_n),
    .hi_strb_n   (hi_strb_n),
    .lo_strb_n   (lo_strb_n),
    .rd_wr_n     (rd_wr_n),
    .wdata_out   (wdata_out),
    .data_oe     (data_oe),
    .done        (done),
    .err         (err)
  );
endmodule

// File: rtl/bus_wr_seq_chk.sv
module bus_wr_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_oe,
  input logic              addr_strb_n,
  input logic              hi_strb_n,
  input logic              lo_strb_n,
  input logic              rd_wr_n,
  input logic [DATA_W-1:0] wdata_out,
  input logic              data_oe,
  input logic              done,
  input logic              err
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |-> (addr_strb_n && hi_strb_n && lo_strb_n && rd_wr_n && !data_oe && !done && !err));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && $past(addr_oe)) |-> $stable(addr_out));

  // R4
  data_after_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_wr_n) |=> $rose(data_oe));

  // R5
  strobe_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_strb_n || !lo_strb_n) |-> (!addr_strb_n && !rd_wr_n && data_oe));

  // R8
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> (!done && !err && !addr_oe));

  // R7
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R8
  end_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (addr_strb_n && hi_strb_n && lo_strb_n && addr_oe));
endmodule

bind bus_wr_seq bus_wr_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .addr_out    (addr_out),
  .addr_oe     (addr_oe),
  .addr_strb_n (addr_strb_n),
  .hi_strb_n   (hi_strb_n),
  .lo_strb_n   (lo_strb_n),
  .rd_wr_n     (rd_wr_n),
  .wdata_out   (wdata_out),
  .data_oe     (data_oe),
  .done        (done),
  .err         (err)
);

// File: tb/bus_wr_seq_tb.sv
module bus_wr_seq_tb;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int FC_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [FC_W-1:0]   fc_in = '0;
  logic [1:0]        be_in = '0;
  logic [DATA_W-1:0] wdata_in = '0;
  logic              ack_n = 1'b1;
  logic              buserr_n = 1'b1;
  logic [ADDR_W-1:0] addr_out;
  logic [FC_W-1:0]   fc_out;
  logic              addr_oe, addr_strb_n, hi_strb_n, lo_strb_n, rd_wr_n;
  logic [DATA_W-1:0] wdata_out;
  logic              data_oe, done, err;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bus_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .fc_in(fc_in),
    .be_in(be_in), .wdata_in(wdata_in), .ack_n(ack_n), .buserr_n(buserr_n),
    .addr_out(addr_out), .fc_out(fc_out), .addr_oe(addr_oe),
    .addr_strb_n(addr_strb_n), .hi_strb_n(hi_strb_n), .lo_strb_n(lo_strb_n),
    .rd_wr_n(rd_wr_n), .wdata_out(wdata_out), .data_oe(data_oe),
    .done(done), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected-value helpers: tick index i counts from 0 (half-phase 12),
  // k is the number of wait clocks.
  function automatic bit in_rng(int i, int lo, int hi);
    return (i >= lo) && (i <= hi);
  endfunction

  task automatic check_idle(input string why);
    chk({"R1 addr_strb_n ", why}, addr_strb_n, 1);
    chk({"R1 hi_strb_n ", why}, hi_strb_n, 1);
    chk({"R1 lo_strb_n ", why}, lo_strb_n, 1);
    chk({"R1 rd_wr_n ", why}, rd_wr_n, 1);
    chk({"R1 addr_oe ", why}, addr_oe, 0);
    chk({"R1 data_oe ", why}, data_oe, 0);
    chk({"R1 done ", why}, done, 0);
    chk({"R1 err ", why}, err, 0);
  endtask

  task automatic run_cycle(input int k, input logic [1:0] be, input bit use_berr,
                           input bit use_ack, input bit early, input bit disturb);
    logic [ADDR_W-1:0] a;
    logic [FC_W-1:0]   f;
    logic [DATA_W-1:0] d;
    int last;
    a = ADDR_W'($urandom);
    f = FC_W'($urandom);
    d = DATA_W'($urandom);
    last = 8 + 2 * k;
    @(negedge clk);
    addr_in = a; fc_in = f; be_in = be; wdata_in = d; start = 1'b1;
    ack_n = !(early && use_ack);
    buserr_n = !(early && use_berr);
    for (int i = 0; i <= last; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      if (disturb && i == 1) begin
        addr_in = ~a; fc_in = ~f; be_in = ~be; wdata_in = ~d;
      end
      if (disturb) start = (i >= 2 && i <= 4);
      if (i == last) begin
        // R9 a second start is not taken; R1 block back at rest
        check_idle("after cycle");
      end else begin
        chk("R2 addr_oe", addr_oe, 1);
        chk("R2 addr_strb_n", addr_strb_n, !in_rng(i, 0, last - 2));
        chk("R2 addr_out", addr_out, a);
        chk("R2 fc_out", fc_out, f);
        chk("R3 rd_wr_n", rd_wr_n, !in_rng(i, 2, last - 1));
        chk("R4 data_oe", data_oe, in_rng(i, 3, last - 1));
        if (in_rng(i, 3, last - 1)) chk("R4 R9 wdata_out", wdata_out, d);
        chk("R5 R6 hi_strb_n", hi_strb_n, !(be[1] && in_rng(i, 4, last - 2)));
        chk("R5 R6 lo_strb_n", lo_strb_n, !(be[0] && in_rng(i, 4, last - 2)));
        chk("R7 R8 done", done, (i == last - 1) && !use_berr);
        chk("R7 R8 err", err, (i == last - 1) && use_berr);
      end
      // terminations presented from the k-th sample on until the cycle ends
      if (!early) begin
        ack_n    = !(use_ack  && in_rng(i, 4 + 2 * k, last - 2));
        buserr_n = !(use_berr && in_rng(i, 4 + 2 * k, last - 2));
      end
      if (i >= last - 2) begin
        ack_n = 1'b1;
        buserr_n = 1'b1;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 outputs at rest during reset
    check_idle("in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("after reset");

    // R6 acknowledge with 0..6 waits, word write
    for (int k = 0; k <= 6; k++) run_cycle(k, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    // R5 each lane on its own, and no lane
    run_cycle(1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    run_cycle(0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
    run_cycle(2, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    // R7 bus error, and bus error together with acknowledge
    run_cycle(0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
    run_cycle(3, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
    run_cycle(2, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    // R6 termination already low from the start of the cycle
    run_cycle(0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    // R9 start and input changes during an active cycle
    run_cycle(1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
    run_cycle(0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1);

    for (int n = 0; n < 40; n++) begin
      int kk;
      bit be_r, ack_r;
      kk = int'($urandom_range(0, 5));
      be_r = 1'($urandom);
      ack_r = 1'($urandom);
      run_cycle(kk, 2'($urandom), be_r, ack_r || !be_r, 1'b0, 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule